// File: doc/BRIEF.md
# Two-by-Two Stride-Two Pooling Engine

This engine shrinks a signed feature map stored in a word-addressed memory. The map is cut into non-overlapping 2x2 tiles with a stride of 2, and each tile becomes a single output element. In max mode the output is the largest of the four values. In average mode the four values are added and the sum is shifted right by two. The element format is chosen when the job starts: a signed byte in the low half of each memory word, or a signed halfword that fills the whole word.

A controller supplies the map width and height, the mode and the element format, then pulses `start`. The engine issues one read per cycle, with four reads for each output. It writes each result to an output buffer through a separate write port and pulses `done` once the job is complete. The address of input element (row r, column k) is r*W + k. The address of output (l, c) is l*Wo + c.

Top module: `pool2x2_engine`

## Requirements
- R1: After reset, `rd_en`, `wr_en` and `done` are low, and they stay low until `start` is seen.
- R2: Wo = floor(W/2) and Ho = floor(H/2). Output (l,c) reads rows 2l and 2l+1 and columns 2c and 2c+1, at addresses row*W + column. A trailing odd row or column is never read.
- R3: When `avg_mode` is 0 at start, each output is the signed maximum of its four inputs.
- R4: When `avg_mode` is 1 at start, each output is the four-input sum, formed without overflow, then arithmetically shifted right by 2. This rounds toward minus infinity.
- R5: When `half_mode` is 0 at start, each element is `rd_data[7:0]` sign-extended, bits 15:8 are ignored, and `wr_data` is the byte result sign-extended to 16 bits. When `half_mode` is 1, all 16 bits form the element.
- R6: Outputs are written in column-major order (c outer, l inner), one write per output, with `wr_addr` = l*Wo + c.
- R7: `rd_data` is consumed one cycle after its `rd_en`. Reads are issued on consecutive cycles, 4*Wo*Ho in total. Within a tile they go top-left, top-right, bottom-left, bottom-right.
- R8: `done` is a one-cycle pulse in the cycle after the final write. If `start` is high in cycle 0, `done` is high in cycle 4*Wo*Ho+3.
- R9: If Wo or Ho is zero, there are no reads and no writes, and `done` pulses in cycle 1.
- R10: Width, height and modes are captured when `start` is accepted. A `start` that arrives while a job is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a job; only accepted while idle |
| avg_mode | input | 1 | 1 = average, 0 = max |
| half_mode | input | 1 | 1 = signed halfword elements, 0 = signed bytes in bits 7:0 |
| width | input | 8 | Input map width W |
| height | input | 8 | Input map height H |
| rd_en | output | 1 | Read request |
| rd_addr | output | 17 | Read element address |
| rd_data | input | 16 | Read data, valid one cycle after `rd_en` |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | 17 | Output element address |
| wr_data | output | 16 | Pooled result |
| done | output | 1 | One-cycle completion pulse |

## Verification
Cycles are counted from the cycle in which `start` is high, which is cycle 0. Reads start in cycle 1. The write for a tile appears two cycles after its fourth read, and `done` is due in cycle 4*Wo*Ho+3. An empty job finishes in cycle 1. The bench drives inputs and samples outputs on falling edges. A memory model returns data one cycle after each read. A driver task queues the expected address and value for each output in column-major order. A monitor pops the queue on every write and counts reads. After `done`, the bench compares the latency, the read and write totals, and the empty queue against their expected values.

// File: rtl/pool_pkg.sv
// Shared types for the pooling engine.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pool_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Position of a read inside its 2x2 tile.
    typedef enum logic [1:0] {
        TILE_TL = 2'd0,
        TILE_TR = 2'd1,
        TILE_BL = 2'd2,
        TILE_BR = 2'd3
    } tile_pos_e;
endpackage

// File: rtl/pool_seq.sv
// Job sequencer: captures the job on start and walks the output grid in
// column-major order. It issues one read per cycle (four per tile) and
// tags each read with its tile position, output address and modes.
// Assumes the memory answers each read exactly one cycle later.
module pool_seq
    import pool_pkg::*;
#(
    parameter int DIM_W  = 8,
    parameter int ADDR_W = 2*DIM_W+1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              avg_i,
    input  logic              half_i,
    input  logic [DIM_W-1:0]  width_i,
    input  logic [DIM_W-1:0]  height_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [1:0]        pos_o,
    output logic              last_o,
    output logic [ADDR_W-1:0] out_addr_o,
    output logic              avg_o,
    output logic              half_o,
    output logic              empty_done_o
);
    seq_state_e        state_q;
    logic [DIM_W-1:0]  w_q, wo_q, ho_q;
    logic [DIM_W-1:0]  col_q, row_q;
    logic [1:0]        pos_q;
    logic              avg_q, half_q, empty_q;
    logic              running, tile_end, col_end, row_end;
    logic [DIM_W-1:0]  wo_new, ho_new;
    logic [ADDR_W-1:0] in_row, in_col, w_ext, wo_ext, l_ext, c_ext;

    // Output grid size of the job being requested.
    always_comb begin
        wo_new = width_i >> 1;
        ho_new = height_i >> 1;
    end

    // Status of the walk through the output grid.
    always_comb begin
        running  = (state_q == SEQ_RUN);
        tile_end = (pos_q == TILE_BR);
        row_end  = (row_q == ho_q - 1'b1);
        col_end  = (col_q == wo_q - 1'b1);
    end

    // Job capture, then tile position, output row and output column counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            w_q     <= '0;
            wo_q    <= '0;
            ho_q    <= '0;
            col_q   <= '0;
            row_q   <= '0;
            pos_q   <= '0;
            avg_q   <= 1'b0;
            half_q  <= 1'b0;
            empty_q <= 1'b0;
        end else begin
            empty_q <= 1'b0;
            if (state_q == SEQ_IDLE) begin
                if (start_i) begin
                    w_q    <= width_i;
                    wo_q   <= wo_new;
                    ho_q   <= ho_new;
                    avg_q  <= avg_i;
                    half_q <= half_i;
                    col_q  <= '0;
                    row_q  <= '0;
                    pos_q  <= '0;
                    if (wo_new == '0 || ho_new == '0) begin
                        empty_q <= 1'b1;
                    end else begin
                        state_q <= SEQ_RUN;
                    end
                end
            end else begin
                pos_q <= pos_q + 2'd1;
                if (tile_end) begin
                    if (row_end) begin
                        row_q <= '0;
                        if (col_end) begin
                            state_q <= SEQ_IDLE;
                        end else begin
                            col_q <= col_q + 1'b1;
                        end
                    end else begin
                        row_q <= row_q + 1'b1;
                    end
                end
            end
        end
    end

    // Read and output addresses, computed from the counters.
    always_comb begin
        in_row     = ADDR_W'({row_q, pos_q[1]});
        in_col     = ADDR_W'({col_q, pos_q[0]});
        w_ext      = ADDR_W'(w_q);
        wo_ext     = ADDR_W'(wo_q);
        l_ext      = ADDR_W'(row_q);
        c_ext      = ADDR_W'(col_q);
        rd_en_o    = running;
        rd_addr_o  = in_row * w_ext + in_col;
        out_addr_o = l_ext * wo_ext + c_ext;
        pos_o      = pos_q;
        last_o     = running && tile_end && row_end && col_end;
        avg_o      = avg_q;
        half_o     = half_q;
        empty_done_o = empty_q;
    end

    // R10
    hold_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running && !last_o |=> running && $stable(w_q) && $stable(avg_q) && $stable(half_q));

    // R9
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_done_o |-> !rd_en_o && !$past(running));
endmodule

// File: rtl/pool_reduce.sv
// Reduction datapath: one accumulator serves both modes. It keeps the
// running max or the running sum of a tile and finishes on the fourth
// element. Assumes the tags arrive with the read and that read data
// comes one cycle after its tag.
module pool_reduce
    import pool_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 17,
    localparam int BYTE_W = DATA_W/2,
    localparam int SUM_W  = DATA_W+2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tag_v_i,
    input  logic [1:0]        pos_i,
    input  logic              last_i,
    input  logic [ADDR_W-1:0] out_addr_i,
    input  logic              avg_i,
    input  logic              half_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              done_o
);
    logic              s_v, s_last, s_avg, s_half;
    logic [1:0]        s_pos;
    logic [ADDR_W-1:0] s_addr;
    logic signed [SUM_W-1:0] elem, acc_q, hold_q;
    logic signed [SUM_W-1:0] pair_max, low_max, tile_max, tile_sum, tile_avg;
    logic [DATA_W-1:0] result;
    logic              wr_last_q;

    // Delay the tags by one cycle so they line up with the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_v    <= 1'b0;
            s_pos  <= '0;
            s_last <= 1'b0;
            s_addr <= '0;
            s_avg  <= 1'b0;
            s_half <= 1'b0;
        end else begin
            s_v    <= tag_v_i;
            s_pos  <= pos_i;
            s_last <= last_i;
            s_addr <= out_addr_i;
            s_avg  <= avg_i;
            s_half <= half_i;
        end
    end

    // Widen the element by sign extension, using the selected format.
    always_comb begin
        if (s_half) begin
            elem = {{(SUM_W-DATA_W){rd_data_i[DATA_W-1]}}, rd_data_i};
        end else begin
            elem = {{(SUM_W-BYTE_W){rd_data_i[BYTE_W-1]}}, rd_data_i[BYTE_W-1:0]};
        end
    end

    // Candidate results for both modes.
    always_comb begin
        pair_max = (acc_q > elem) ? acc_q : elem;
        low_max  = (hold_q > elem) ? hold_q : elem;
        tile_max = (acc_q > low_max) ? acc_q : low_max;
        tile_sum = acc_q + hold_q + elem;
        tile_avg = tile_sum >>> 2;
        result   = s_avg ? tile_avg[DATA_W-1:0] : tile_max[DATA_W-1:0];
    end

    // Accumulate the top pair, hold the bottom-left element, and emit on the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            hold_q    <= '0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
            wr_last_q <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            if (s_v) begin
                case (s_pos)
                    TILE_TL: acc_q  <= elem;
                    TILE_TR: acc_q  <= s_avg ? (acc_q + elem) : pair_max;
                    TILE_BL: hold_q <= elem;
                    default: ;
                endcase
            end
            wr_en_o   <= s_v && (s_pos == TILE_BR);
            wr_addr_o <= s_addr;
            wr_data_o <= result;
            wr_last_q <= s_v && s_last;
            done_o    <= wr_en_o && wr_last_q;
        end
    end

    // R7
    tile_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_v && s_pos != TILE_BR |=> s_v && (s_pos == $past(s_pos) + 2'd1));

    // R5
    byte_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o && !$past(s_half) |-> wr_data_o[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){wr_data_o[BYTE_W-1]}});

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/pool2x2_engine.sv
// Top of the 2x2 stride-2 pooling engine: the sequencer drives reads and
// the reduction datapath turns each tile's four elements into one write.
// Assumes a memory with one-cycle read latency and an always-ready write port.
module pool2x2_engine #(
    parameter int DATA_W = 16,
    parameter int DIM_W  = 8,
    localparam int ADDR_W = 2*DIM_W+1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              avg_mode,
    input  logic              half_mode,
    input  logic [DIM_W-1:0]  width,
    input  logic [DIM_W-1:0]  height,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);
    logic [1:0]        pos;
    logic              last, avg_q, half_q, empty_done, red_done;
    logic [ADDR_W-1:0] out_addr;

    pool_seq #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .avg_i(avg_mode),
        .half_i(half_mode), .width_i(width), .height_i(height),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .pos_o(pos), .last_o(last),
        .out_addr_o(out_addr), .avg_o(avg_q), .half_o(half_q),
        .empty_done_o(empty_done)
    );

    pool_reduce #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_reduce (
        .clk(clk), .rst_n(rst_n), .tag_v_i(rd_en), .pos_i(pos), .last_i(last),
        .out_addr_i(out_addr), .avg_i(avg_q), .half_i(half_q),
        .rd_data_i(rd_data), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
        .wr_data_o(wr_data), .done_o(red_done)
    );

    // Merge the completion of a normal job and of an empty job.
    always_comb done = red_done || empty_done;

    // R1
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !rd_en && !wr_en && !done);
endmodule

// File: tb/pool2x2_engine_bench.sv
module pool2x2_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, avg_mode = 1'b0, half_mode = 1'b0;
    logic [7:0]  width = '0, height = '0;
    logic        rd_en, wr_en, done;
    logic [16:0] rd_addr, wr_addr;
    logic [15:0] rd_data, wr_data;
    logic [15:0] mem [256];

    int errors = 0;
    int checks = 0;
    int n_rd = 0;
    int n_wr = 0;
    string cur_req = "R3";
    logic [32:0] exp_q[$];

    always #4 clk = ~clk;

    pool2x2_engine u_pool2x2_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .avg_mode(avg_mode),
        .half_mode(half_mode), .width(width), .height(height),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
    );

    // Memory model with one-cycle read latency.
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[7:0]];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: count reads, pop and compare each write.
    always @(negedge clk) begin
        if (rst_n && rd_en) n_rd++;
        if (rst_n && wr_en) begin
            n_wr++;
            if (exp_q.size() == 0) begin
                check(0, "R6", "unexpected write", int'(wr_addr), -1);
            end else begin
                logic [32:0] e;
                e = exp_q.pop_front();
                check(wr_addr == e[32:16], "R6", "write address", int'(wr_addr), int'(e[32:16]));
                check(wr_data == e[15:0], cur_req, "write data",
                      int'($signed(wr_data)), int'($signed(e[15:0])));
            end
        end
    end

    function automatic int elem_of(input int addr, input bit half);
        logic [15:0] v;
        v = mem[addr];
        return half ? int'($signed(v)) : int'($signed(v[7:0]));
    endfunction

    // Driver: queue the expected results, run the job, check latency and counts.
    task automatic run(input int w, input int h, input bit avg, input bit half,
                       input bit inject, input string req);
        int wo, ho, n, cnt;
        wo = w / 2;
        ho = h / 2;
        n = 4 * wo * ho;
        cur_req = req;
        for (int c = 0; c < wo; c++) begin
            for (int l = 0; l < ho; l++) begin
                int a, b, d, e, r;
                a = elem_of((2*l)*w + 2*c, half);
                b = elem_of((2*l)*w + 2*c + 1, half);
                d = elem_of((2*l+1)*w + 2*c, half);
                e = elem_of((2*l+1)*w + 2*c + 1, half);
                if (avg) r = (a + b + d + e) >>> 2;
                else begin
                    r = a;
                    if (b > r) r = b;
                    if (d > r) r = d;
                    if (e > r) r = e;
                end
                exp_q.push_back({17'(l*wo + c), 16'(r)});
            end
        end
        n_rd = 0;
        n_wr = 0;
        @(negedge clk);
        width = 8'(w); height = 8'(h); avg_mode = avg; half_mode = half; start = 1'b1;
        cnt = 0;
        while (1) begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) start = 1'b0;
            if (inject && cnt == 5) begin
                start = 1'b1; width = 8'd2; height = 8'd2; avg_mode = ~avg; half_mode = ~half;
            end
            if (inject && cnt == 6) begin
                start = 1'b0; width = 8'(w); height = 8'(h); avg_mode = avg; half_mode = half;
            end
            if (done || cnt > 3000) break;
        end
        check(cnt == n + 3, "R8", "done cycle", cnt, n + 3);
        @(negedge clk);
        check(!done, "R8", "done width", int'(done), 0);
        check(n_rd == n, "R7", "read count", n_rd, n);
        check(n_wr == wo * ho, inject ? "R10" : "R2", "write count", n_wr, wo * ho);
        check(exp_q.size() == 0, "R6", "missing writes", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 256; i++) mem[i] = 16'((i * 40503 + seed * 977) ^ (i << 9));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        fill(1);
        repeat (3) @(negedge clk);
        // R1: quiet after reset
        check(!rd_en && !wr_en && !done, "R1", "idle outputs", int'({rd_en, wr_en, done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!rd_en && !wr_en && !done, "R1", "idle after release", int'({rd_en, wr_en, done}), 0);

        run(6, 4, 1'b0, 1'b1, 1'b0, "R3");       // max, halfwords
        fill(2);
        mem[0] = 16'h8000; mem[1] = 16'h8000; mem[5] = 16'h8000; mem[6] = 16'h8001;
        mem[2] = 16'h7fff; mem[3] = 16'h7fff; mem[7] = 16'h7fff; mem[8] = 16'h7ffe;
        run(5, 5, 1'b1, 1'b1, 1'b0, "R4");       // avg, extremes, odd trailing row/col (R2)
        fill(3);
        run(4, 4, 1'b0, 1'b0, 1'b0, "R5");       // max, bytes with junk upper bits
        fill(4);
        run(7, 3, 1'b1, 1'b0, 1'b0, "R5");       // avg, bytes, odd sizes (R2)
        fill(5);
        run(8, 6, 1'b1, 1'b1, 1'b1, "R10");      // start while busy is ignored

        // R9: empty job
        begin
            int cnt;
            n_rd = 0; n_wr = 0;
            @(negedge clk);
            width = 8'd1; height = 8'd4; start = 1'b1;
            cnt = 0;
            while (1) begin
                @(negedge clk);
                cnt++;
                start = 1'b0;
                if (done || cnt > 50) break;
            end
            check(cnt == 1, "R9", "empty done cycle", cnt, 1);
            repeat (4) @(negedge clk);
            check(n_rd == 0 && n_wr == 0, "R9", "empty traffic", n_rd + n_wr, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule